// File: doc/BRIEF.md
# Off-State Load Diagnostic Controller

This block watches every output channel of a multi-channel load switch while that channel's power stage is off. For each channel it receives a digital comparator flag that is high when the output voltage is above the open-load threshold. It also receives a channel-on indication from the switch control logic. The comparator flag passes through a two-flop synchronizer and a four-sample debounce. When detection is enabled and the stage is off, the block drives a pull-up current source with a configurable strength and reports a live open-load status bit. The status is not latched: it clears as soon as the output drops back below the threshold.

A high output can come from a disconnected load or from a short to the supply. To tell these apart, software can arm a per-channel pull-down test. When a high output is seen, the block releases the pull-up and applies a pull-down. It waits a programmable settling time and then samples the filtered comparator. If the output is still high, the short-to-supply status bit is set. A global active-low fault output is asserted while any status bit is set and not masked. A register port with a single-cycle write strobe and a combinational read gives access to configuration, masks, status and the settling time.

Top module: `offdiag_ctrl`

## Requirements
- R1: Detection for a channel is active only while its `ch_on` bit is 0 and bit 0 of its config register is 1 (config registers are at address 0 for channel 0 and address 1 for channel 1). While it is active, `pu_en` for that channel is 1 unless a pull-down test is running. While it is inactive, the channel's open-load status bit reads 0.
- R2: Open-load status bits are live: status register bits [1:0] (address 3, bit i for channel i) follow the filtered comparator and clear when the comparator returns low.
- R3: `fault_n` is 0 exactly when some status bit is set whose mask bit is 0. It is updated one clock after the status. The mask register is at address 2: bits [1:0] mask the open-load bits and bits [3:2] mask the short bits.
- R4: `pu_str` carries each channel's config bits [3:2], channel i in bits [2i+1:2i].
- R5: When config bit 1 (pull-down test enable) is 1, detection is active and the filtered comparator is high, the block asserts `pd_en` and releases `pu_en`. `pd_en` stays asserted for exactly the settle count in clock cycles.
- R6: At the end of the settling time, the short status bit (status bit 2+i) is set if the filtered comparator is still high, and stays 0 otherwise. Afterwards `pd_en` is released and the pull-up returns.
- R7: A short status bit clears when its test enable bit is written 0 or when its channel is turned on.
- R8: `pu_en` and `pd_en` are both forced to 0 while the channel is on, and they are never 1 together.
- R9: The settle count register (address 4, 8 bits) resets to 32. Writes below 16 are stored as 16.
- R10: A comparator pulse shorter than four clock cycles has no effect on status or `fault_n`.
- R11: After reset, `fault_n` is 1, `pu_en` and `pd_en` are 0, and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_on | input | NCH | Channel power stage is on |
| cmp_hi | input | NCH | Comparator: output above open-load threshold |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| pu_en | output | NCH | Pull-up current source enable |
| pu_str | output | NCH*SW | Pull-up strength code per channel |
| pd_en | output | NCH | Output pull-down enable |
| fault_n | output | 1 | Global maskable fault, active low |

## Verification
Random combinations of channel on/off, detection enable, comparator level, strength code and masks are used to check the live status. These runs show that status appears only in the off state with detection enabled, and that the mask only blocks `fault_n`. Directed pull-down tests are run in two ways. In one, the comparator stays high, which is how a short looks. In the other, it drops while the pull-down is applied, which is how an open load looks. Comparing the two runs shows that the short bit depends on the value sampled at the end of the settling time, and the count of `pd_en` cycles is checked against the settle register. Short comparator glitches, the clamp of the settle value, and clearing the short bit by disabling the test or turning the channel on are each tested on their own.

// File: rtl/offdiag_pkg.sv
`timescale 1ns/1ps
package offdiag_pkg;
  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_SETTLE = 2'd1,
    TS_DONE   = 2'd2
  } tst_state_e;

  localparam int CFG_OL_BIT  = 0;
  localparam int CFG_PD_BIT  = 1;
  localparam int CFG_STR_LSB = 2;
  localparam int SETTLE_MIN  = 16;
  localparam int SETTLE_RST  = 32;
endpackage

// File: rtl/offdiag_filt.sv
`timescale 1ns/1ps
module offdiag_filt #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(DEB) + 1;

  logic          s1_q, s2_q, filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (s2_q != filt_q) begin
      if (cnt_q == CW'(DEB - 1)) begin
        filt_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/offdiag_chan.sv
`timescale 1ns/1ps
module offdiag_chan
  import offdiag_pkg::*;
#(
  parameter int SETW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ch_on,
  input  logic            hi,
  input  logic            ol_en,
  input  logic            pd_req,
  input  logic [SETW-1:0] settle,
  output logic            pu_en,
  output logic            pd_en,
  output logic            ol_stat,
  output logic            sh_stat
);
  tst_state_e      st_q, st_d;
  logic [SETW-1:0] cnt_q, cnt_d;
  logic            ol_q, ol_d, sh_q, sh_d;
  logic            active, cnt_en;

  assign active = ~ch_on & ol_en;
  assign cnt_en = (st_q == TS_SETTLE) || (st_d == TS_SETTLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    case (st_q)
      TS_IDLE: begin
        if (active && pd_req && hi) begin
          st_d  = TS_SETTLE;
          cnt_d = '0;
        end
      end
      TS_SETTLE: begin
        if (!active || !pd_req) begin
          st_d = TS_IDLE;
        end else if (cnt_q == settle - 1'b1) begin
          st_d = TS_DONE;
          sh_d = hi;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      TS_DONE: begin
        if (!active || !pd_req) st_d = TS_IDLE;
      end
      default: st_d = TS_IDLE;
    endcase
    if (ch_on || !pd_req) sh_d = 1'b0;
    ol_d = ((st_q == TS_SETTLE) && active) ? ol_q : (active & hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TS_IDLE;
      ol_q <= 1'b0;
      sh_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ol_q <= ol_d;
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pu_en   = active & (st_q != TS_SETTLE);
  assign pd_en   = active & (st_q == TS_SETTLE);
  assign ol_stat = ol_q;
  assign sh_stat = sh_q;
endmodule

// File: rtl/offdiag_regs.sv
`timescale 1ns/1ps
module offdiag_regs
  import offdiag_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SW   = 2,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int SETW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NCH-1:0]  st_ol,
  input  logic [NCH-1:0]  st_sh,
  output logic [NCH-1:0]  ol_en,
  output logic [NCH-1:0]  pd_req,
  output logic [NCH*SW-1:0] str,
  output logic [NCH-1:0]  mask_ol,
  output logic [NCH-1:0]  mask_sh,
  output logic [SETW-1:0] settle
);
  localparam int CW     = SW + 2;
  localparam int A_MASK = NCH;
  localparam int A_STAT = NCH + 1;
  localparam int A_SETL = NCH + 2;

  logic [CW-1:0]    cfg_q [NCH];
  logic [2*NCH-1:0] mask_q;
  logic [SETW-1:0]  settle_q, settle_d;
  logic             mask_we, settle_we;

  assign mask_we   = wr && (addr == AW'(A_MASK));
  assign settle_we = wr && (addr == AW'(A_SETL));
  assign settle_d  = (wdata[SETW-1:0] < SETW'(SETTLE_MIN)) ? SETW'(SETTLE_MIN)
                                                           : wdata[SETW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_cfg
    logic cfg_we;
    assign cfg_we = wr && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (cfg_we) begin
        cfg_q[i] <= wdata[CW-1:0];
      end
    end
    assign ol_en[i]          = cfg_q[i][CFG_OL_BIT];
    assign pd_req[i]         = cfg_q[i][CFG_PD_BIT];
    assign str[i*SW +: SW]   = cfg_q[i][CFG_STR_LSB +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wdata[2*NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= SETW'(SETTLE_RST);
    end else if (settle_we) begin
      settle_q <= settle_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rdata[CW-1:0] = cfg_q[i];
    end
    if (addr == AW'(A_MASK)) rdata[2*NCH-1:0] = mask_q;
    if (addr == AW'(A_STAT)) rdata[2*NCH-1:0] = {st_sh, st_ol};
    if (addr == AW'(A_SETL)) rdata[SETW-1:0]  = settle_q;
  end

  assign mask_ol = mask_q[NCH-1:0];
  assign mask_sh = mask_q[2*NCH-1:NCH];
  assign settle  = settle_q;
endmodule

// File: rtl/offdiag_ctrl.sv
`timescale 1ns/1ps
module offdiag_ctrl #(
  parameter int NCH  = 2,
  parameter int SW   = 2,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int DEB  = 4,
  parameter int SETW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_on,
  input  logic [NCH-1:0]    cmp_hi,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NCH-1:0]    pu_en,
  output logic [NCH*SW-1:0] pu_str,
  output logic [NCH-1:0]    pd_en,
  output logic              fault_n
);
  logic            rst_meta, rst_s;
  logic [NCH-1:0]  hi_f, ol_en, pd_req, ol_stat, sh_stat, mask_ol, mask_sh;
  logic [SETW-1:0] settle_q;
  logic            fault_d, fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  offdiag_regs #(.NCH(NCH), .SW(SW), .AW(AW), .DW(DW), .SETW(SETW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .st_ol(ol_stat), .st_sh(sh_stat), .ol_en(ol_en),
    .pd_req(pd_req), .str(pu_str), .mask_ol(mask_ol), .mask_sh(mask_sh),
    .settle(settle_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    offdiag_filt #(.DEB(DEB)) u_filt (
      .clk(clk), .rst_n(rst_s), .raw(cmp_hi[i]), .filt(hi_f[i])
    );
    offdiag_chan #(.SETW(SETW)) u_chan (
      .clk(clk), .rst_n(rst_s), .ch_on(ch_on[i]), .hi(hi_f[i]),
      .ol_en(ol_en[i]), .pd_req(pd_req[i]), .settle(settle_q),
      .pu_en(pu_en[i]), .pd_en(pd_en[i]), .ol_stat(ol_stat[i]),
      .sh_stat(sh_stat[i])
    );
  end

  assign fault_d = ~|((ol_stat & ~mask_ol) | (sh_stat & ~mask_sh));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fault_q <= 1'b1;
    end else begin
      fault_q <= fault_d;
    end
  end

  assign fault_n = fault_q;
endmodule

// File: rtl/offdiag_chk.sv
`timescale 1ns/1ps
module offdiag_chk #(
  parameter int NCH  = 2,
  parameter int SETW = 8
) (
  input logic            clk,
  input logic            rst_s,
  input logic [NCH-1:0]  ch_on,
  input logic [NCH-1:0]  pu_en,
  input logic [NCH-1:0]  pd_en,
  input logic [NCH-1:0]  ol_stat,
  input logic [NCH-1:0]  sh_stat,
  input logic [NCH-1:0]  mask_ol,
  input logic [NCH-1:0]  mask_sh,
  input logic [SETW-1:0] settle,
  input logic            fault_n
);
  AST_PU_PD_EXCL: assert property (@(posedge clk) disable iff (!rst_s)
    (pu_en & pd_en) == '0); // R8
  AST_OFF_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_s)
    (ch_on & (pu_en | pd_en)) == '0); // R8
  AST_FAULT_MAP: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (fault_n == !$past(|((ol_stat & ~mask_ol) | (sh_stat & ~mask_sh))))); // R3
  AST_SETTLE_FLOOR: assert property (@(posedge clk) disable iff (!rst_s)
    settle >= SETW'(16)); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_c
    AST_STAT_QUIET_ON: assert property (@(posedge clk) disable iff (!rst_s)
      ch_on[i] |=> !ol_stat[i]); // R1
    AST_SHORT_NEEDS_PD: assert property (@(posedge clk) disable iff (!rst_s)
      $rose(sh_stat[i]) |-> $past(pd_en[i])); // R6
    AST_SHORT_CLR_ON: assert property (@(posedge clk) disable iff (!rst_s)
      ch_on[i] |=> !sh_stat[i]); // R7
  end
endmodule

bind offdiag_ctrl offdiag_chk #(.NCH(NCH), .SETW(SETW)) u_chk (
  .clk(clk), .rst_s(rst_s), .ch_on(ch_on), .pu_en(pu_en), .pd_en(pd_en),
  .ol_stat(ol_stat), .sh_stat(sh_stat), .mask_ol(mask_ol), .mask_sh(mask_sh),
  .settle(settle_q), .fault_n(fault_n)
);

// File: tb/offdiag_ctrl_test.sv
`timescale 1ns/1ps
module offdiag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ch_on, cmp_hi, pu_en, pd_en;
  logic [3:0] pu_str;
  logic       reg_wr, fault_n;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  offdiag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .cmp_hi(cmp_hi), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pu_en(pu_en), .pu_str(pu_str), .pd_en(pd_en), .fault_n(fault_n)
  );

  function automatic logic [1:0] exp_ol(logic [1:0] on, logic [1:0] en, logic [1:0] c);
    return ~on & en & c;
  endfunction

  function automatic logic exp_fault_n(logic [1:0] ol, logic [1:0] sh, logic [3:0] m);
    return ~|((ol & ~m[1:0]) | (sh & ~m[3:2]));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pd_run(int settle, bit keep_hi, bit exp_short);
    logic [7:0] v;
    int n = 0, w = 0;
    bit pu_seen = 0;
    ch_on = 2'b00; cmp_hi[0] = 1'b1;
    wr(3'd0, 8'h05);
    cyc(14);
    wr(3'd0, 8'h07);
    while (!pd_en[0] && w < 20) begin cyc(1); w++; end
    while (pd_en[0] && n < 400) begin
      if (!keep_hi) cmp_hi[0] = 1'b0;
      if (pu_en[0]) pu_seen = 1;
      n++;
      cyc(1);
    end
    chk("R5 pd_en cycles", n, settle);
    chk("R5 pull-up released during test", pu_seen, 0);
    cyc(10);
    rd(3'd3, v);
    chk("R6 short bit", v[2], exp_short);
    chk("R6 pull-up back after test", {pd_en[0], pu_en[0]}, 2'b01);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h0DD1A6));
    rst_n = 1'b0; ch_on = 2'b00; cmp_hi = 2'b00;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R11 reset state
    chk("R11 fault_n", fault_n, 1);
    chk("R11 pu/pd", {pu_en, pd_en}, 0);
    rd(3'd3, v); chk("R11 status", v, 0);
    rd(3'd4, v); chk("R9 settle reset", v, 32);

    // R9 clamp
    wr(3'd4, 8'd5);   rd(3'd4, v); chk("R9 clamp low", v, 16);
    wr(3'd4, 8'd200); rd(3'd4, v); chk("R9 keep 200", v, 200);
    wr(3'd4, 8'd16);  rd(3'd4, v); chk("R9 keep 16", v, 16);

    // R1 R2 R3 R4 random patterns
    for (int it = 0; it < 40; it++) begin
      logic [1:0] on, en, c;
      logic [1:0] s0, s1;
      logic [3:0] m;
      on = 2'($urandom); en = 2'($urandom); c = 2'($urandom);
      s0 = 2'($urandom); s1 = 2'($urandom); m = 4'($urandom);
      wr(3'd0, {4'b0, s0, 1'b0, en[0]});
      wr(3'd1, {4'b0, s1, 1'b0, en[1]});
      wr(3'd2, {4'b0, m});
      ch_on = on; cmp_hi = c;
      cyc(14);
      rd(3'd3, v);
      chk("R1/R2 status", v, {6'b0, exp_ol(on, en, c)});
      chk("R1 pu_en", pu_en, ~on & en);
      chk("R8 pd_en idle", pd_en, 0);
      chk("R4 pu_str", pu_str, {s1, s0});
      chk("R3 fault_n", fault_n, exp_fault_n(exp_ol(on, en, c), 2'b00, m));
    end

    // R2 live clear and R3 mask
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    ch_on = 2'b00; cmp_hi = 2'b01; wr(3'd0, 8'h01);
    cyc(14); rd(3'd3, v); chk("R2 set", v, 8'h01);
    chk("R3 fault low", fault_n, 0);
    wr(3'd2, 8'h01); cyc(2); chk("R3 masked", fault_n, 1);
    wr(3'd2, 8'h00);
    cmp_hi = 2'b00; cyc(14); rd(3'd3, v); chk("R2 live clear", v, 8'h00);
    chk("R2 fault released", fault_n, 1);

    // R10 glitch
    begin
      bit seen = 0;
      cmp_hi[0] = 1'b1; cyc(3); cmp_hi[0] = 1'b0;
      for (int k = 0; k < 12; k++) begin
        rd(3'd3, v);
        if (v[0] || !fault_n) seen = 1;
        cyc(1);
      end
      chk("R10 3-cycle glitch ignored", seen, 0);
    end

    // R5 R6 short and open
    wr(3'd4, 8'd20);
    pd_run(20, 1, 1);
    chk("R3 fault on short", fault_n, 0);
    wr(3'd0, 8'h05); cyc(3);
    rd(3'd3, v); chk("R7 clear by test disable", v[2], 0);
    wr(3'd4, 8'd40);
    pd_run(40, 0, 0);
    rd(3'd3, v); chk("R2 open clears after test", v[0], 0);
    pd_run(40, 1, 1);
    ch_on[0] = 1'b1; cyc(3);
    rd(3'd3, v); chk("R7 clear by channel on", v[2], 0);
    chk("R8 outputs off when on", {pu_en[0], pd_en[0]}, 2'b00);
    ch_on[0] = 1'b0; wr(3'd0, 8'h00); cmp_hi = 2'b00;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule